// File: doc/BRIEF.md
# Lockable Counter Watchdog

This block supervises software by watching a free-running 16-bit tick counter. Software arms a compare point by writing to a reload address. The new compare high byte is the live counter high byte plus an 8-bit offset. The compare low byte is implied to be 0xFF. If the counter ticks past that point while the watchdog is active, the block raises a single-cycle reset request for the system reset logic. Software must keep writing the reload address often enough to prevent this.

The counter advances on tick enables that a prescaler inside the block derives from the system clock. The divide ratio comes from a 3-bit select. An optional idle-suspend control stops both the prescaler and the counter while the CPU reports that it is idle. A sticky lock bit keeps the watchdog active until the next reset. The clock select and the idle control cannot be changed while the watchdog is active.

Top module: `wdog_core`

## Requirements
- R1: `wd_active` is 1 whenever the enable bit or the lock bit is set, and 0 otherwise.
- R2: The lock bit, once set, stays set until reset. While it is set, writing 0 to the enable bit leaves `wd_active` at 1. Reset clears the lock, so a later write of 0 to the enable bit disables the watchdog.
- R3: With the lock bit clear, writing 0 to the enable bit disables the watchdog. While disabled, reload writes are ignored and `rst_req` stays 0.
- R4: A write to the control register that occurs while the watchdog is active leaves the clock select and the idle-suspend bit unchanged. The enable and lock bits still take the written value.
- R5: After reset the watchdog is enabled, the lock is clear, the select is divide-by-12, the counter is 0 and the offset and compare byte are 0. The first reset request therefore appears 3072 clock cycles after reset is released.
- R6: A reload write samples the counter value H:L and sets the compare byte to H + offset (mod 256); the written data is ignored. The request follows after 256*offset + 256 - L ticks, at the tick where the counter leaves compare:0xFF.
- R7: `rst_req` is high for exactly one cycle per expiry.
- R8: Clock select encoding: 0 gives a tick every 12 cycles, 1 gives a tick every 4 cycles, 2 gives a tick every cycle, and 3 to 7 give a tick every 12 cycles. A select change made while the watchdog is inactive restarts the prescaler phase.
- R9: With the idle-suspend bit set, the counter and the prescaler hold while `cpu_idle` is 1.
- R10: A reload write in the same cycle as the expiry tick wins: no request is issued, and the compare byte takes the new value.
- R11: The register map is as follows. Address 0 is the control register, with bit 0 enable, bit 1 lock, bits 4:2 clock select and bit 5 idle-suspend. Address 1 holds the 8-bit offset. Address 2 is the reload address. A write takes effect on the clock edge where `wr_en` is 1. `count` shows the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Write data |
| cpu_idle | input | 1 | CPU idle indication |
| rst_req | output | 1 | One-cycle reset request |
| wd_active | output | 1 | Watchdog active |
| count | output | 16 | Current counter value |

## Verification
Two functions can fall in the same cycle: the expiry tick and a reload write. The bench selects a tick on every cycle and watches `count` until its low byte reads 0xFF with the compare byte equal to the high byte. It then issues the reload write so that it lands on exactly the edge that would expire. The test passes if `rst_req` stays low for the following 300 cycles. The behavioural model compares `rst_req`, `wd_active` and `count` on every clock, so it also judges that edge.

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int CW       = 16,
  parameter int DIV_SLOW = 12,
  parameter int DIV_MID  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          cpu_idle,
  output logic          rst_req,
  output logic          wd_active,
  output logic [CW-1:0] count
);
  localparam int HW = CW - 8;
  localparam int DW = $clog2(DIV_SLOW);

  logic          en, lock, susp_en, req;
  logic [2:0]    sel;
  logic [7:0]    off;
  logic [HW-1:0] cmp;
  logic [CW-1:0] cnt;
  logic [DW-1:0] div, lim;

  wire active = en | lock;
  wire ctl_wr = wr_en && wr_addr == 2'd0;
  wire off_wr = wr_en && wr_addr == 2'd1;
  wire rld_wr = wr_en && wr_addr == 2'd2 && active;
  wire run    = !(susp_en && cpu_idle);
  wire tick   = run && div == lim;
  wire match  = cnt[CW-1:8] == cmp && cnt[7:0] == 8'hFF;
  wire resel  = ctl_wr && !active && wr_data[4:2] != sel;

  always_comb begin
    case (sel)
      3'd1:    lim = DW'(DIV_MID - 1);
      3'd2:    lim = '0;
      default: lim = DW'(DIV_SLOW - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b1; lock <= 1'b0; susp_en <= 1'b0; sel <= 3'd0;
      off <= '0; cmp <= '0; cnt <= '0; div <= '0; req <= 1'b0;
    end else begin
      if (ctl_wr) begin
        en   <= wr_data[0];
        lock <= lock | wr_data[1];
        if (!active) begin
          sel     <= wr_data[4:2];
          susp_en <= wr_data[5];
        end
      end
      if (off_wr) off <= wr_data;
      if (resel) div <= '0;
      else if (run) div <= tick ? '0 : div + DW'(1);
      if (tick) cnt <= cnt + CW'(1);
      if (rld_wr) cmp <= cnt[CW-1:8] + HW'(off);
      req <= active && tick && match && !rld_wr;
    end
  end

  assign rst_req   = req;
  assign wd_active = active;
  assign count     = cnt;

  assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  assert_lock_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);
  assert_frozen_cfg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> ($stable(sel) && $stable(susp_en)));
  assert_quiet_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_active |=> !rst_req);
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_en && cpu_idle) |=> $stable(count));
endmodule

// File: tb/wdog_core_bench.sv
module wdog_core_bench;
  logic clk = 0, rst_n = 0, wr_en = 0, cpu_idle = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic rst_req, wd_active;
  logic [15:0] count;

  always #2 clk = ~clk;

  wdog_core u_wdog_core (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cpu_idle(cpu_idle), .rst_req(rst_req), .wd_active(wd_active),
    .count(count));

  int checks = 0, errors = 0, ecount = 0, cyc = 0, first_req = -1;
  int m_en, m_lock, m_sel, m_susp, m_off, m_cmp, m_cnt, m_div, m_req;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_en = 1; m_lock = 0; m_sel = 0; m_susp = 0; m_off = 0;
      m_cmp = 0; m_cnt = 0; m_div = 0; m_req = 0;
    end else begin
      int act, runv, lim, tk, mt, rld, nsel;
      ecount++;
      act  = m_en | m_lock;
      runv = !(m_susp && cpu_idle);
      lim  = (m_sel == 1) ? 4 : (m_sel == 2) ? 1 : 12;
      tk   = runv && (m_div + 1 == lim);
      mt   = ((m_cnt / 256) == m_cmp) && (m_cnt % 256 == 255);
      rld  = wr_en && wr_addr == 2 && act;
      nsel = (wr_data >> 2) & 7;
      m_req = act && tk && mt && !rld;
      if (rld) m_cmp = (m_cnt / 256 + m_off) % 256;
      if (tk) m_cnt = (m_cnt + 1) % 65536;
      if (wr_en && wr_addr == 0 && !act && nsel != m_sel) m_div = 0;
      else if (runv) m_div = tk ? 0 : m_div + 1;
      if (wr_en && wr_addr == 0) begin
        m_en = wr_data[0];
        m_lock = m_lock | wr_data[1];
        if (!act) begin m_sel = nsel; m_susp = wr_data[5]; end
      end
      if (wr_en && wr_addr == 1) m_off = wr_data;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(rst_req == m_req, "R7 rst_req vs model", rst_req, m_req);
    chk(wd_active == (m_en | m_lock), "R1 wd_active vs model", wd_active, m_en | m_lock);
    chk(count == m_cnt, "R11 count vs model", count, m_cnt);
    if (rst_req && first_req < 0) first_req = ecount;
  end

  always @(posedge clk) if (cyc > 150000) begin
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [15:0] x;
    int e0, nreq;
    edges(3);
    chk(wd_active == 1, "R5 active at reset", wd_active, 1);
    chk(count == 0, "R5 count at reset", count, 0);
    chk(rst_req == 0, "R5 no request at reset", rst_req, 0);
    rst_n = 1;
    while (ecount < 3080) @(negedge clk);
    chk(first_req == 3072, "R5 first timeout cycle", first_req, 3072);

    wr(0, 8'h00);
    chk(wd_active == 0, "R3 disabled", wd_active, 0);
    wr(2, 8'h00);
    nreq = 0;
    repeat (400) begin @(negedge clk); nreq += rst_req; end
    chk(nreq == 0, "R3 no request while disabled", nreq, 0);

    wr(1, 8'h01);
    wr(0, 8'h09);
    chk(wd_active == 1, "R1 enabled again", wd_active, 1);
    @(negedge clk);
    x = count; e0 = ecount + 1;
    wr_en = 1; wr_addr = 2; wr_data = 8'hA5;
    @(negedge clk); wr_en = 0;
    while (!rst_req && ecount < e0 + 1000) @(negedge clk);
    chk(ecount == e0 + 255 - x[7:0] + 256, "R6 reload timeout", ecount, e0 + 255 - x[7:0] + 256);
    @(negedge clk);
    chk(rst_req == 0, "R7 single cycle", rst_req, 0);

    wr(1, 8'h00);
    wr(2, 8'h00);
    while (count[7:0] != 8'hFF) @(negedge clk);
    wr_en = 1; wr_addr = 2; wr_data = 8'h00;
    @(negedge clk); wr_en = 0;
    nreq = 0;
    repeat (300) begin @(negedge clk); nreq += rst_req; end
    chk(nreq == 0, "R10 reload beats expiry", nreq, 0);

    wr(0, 8'h01);
    x = count; edges(12);
    chk(count == 16'(x + 12), "R4 select write ignored while active", count, 16'(x + 12));

    wr(0, 8'h00);
    wr(0, 8'h29);
    cpu_idle = 1; x = count; edges(20);
    chk(count == x, "R9 counter holds in idle", count, x);
    cpu_idle = 0; x = count; edges(5);
    chk(count == 16'(x + 5), "R9 resumes after idle", count, 16'(x + 5));
    wr(0, 8'h09);
    cpu_idle = 1; x = count; edges(10);
    chk(count == x, "R4 idle bit write ignored while active", count, x);
    cpu_idle = 0;

    wr(0, 8'h00);
    wr(0, 8'h05);
    x = count; edges(40);
    chk(count == 16'(x + 10), "R8 divide by 4", count, 16'(x + 10));

    wr(0, 8'h0B);
    wr(0, 8'h00);
    chk(wd_active == 1, "R2 lock keeps watchdog on", wd_active, 1);
    x = count; edges(40);
    chk(count == 16'(x + 10), "R4 select frozen under lock", count, 16'(x + 10));

    @(negedge clk); rst_n = 0;
    edges(2); rst_n = 1;
    wr(0, 8'h00);
    chk(wd_active == 0, "R2 reset clears lock", wd_active, 0);
    edges(5);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule